// File: doc/BRIEF.md
# Double-Buffered Polarity-Selectable PWM Channel

A single left-aligned pulse-width modulator channel. An up-counter advances on each prescaled clock-enable tick, runs from 0 to period−1 and then wraps. A compare against the active duty value drives the output pin. The polarity input chooses which level each period begins with. When polarity is 1 the duty count is the high time. When polarity is 0 the duty count is the low time.

The period and duty values are each held in a pair of registers: a host-visible buffer and an active copy. While the channel runs, a host write reaches only the buffer. The active copies take the buffered values at the wrap of the counter, so every period shows either the old settings or the new ones in full. While the channel is disabled, a write lands in both copies in the same cycle. The counter is then held at zero and the pin rests at the complement of polarity. A read always returns the buffer.

Top module: `pwm_chan`

## Requirements
- R1: After reset, both the period and the duty buffers read 0xFF, the active copies hold 0xFF, and the counter is 0.
- R2: A duty write while enabled changes only the buffer. The waveform keeps the old duty until the counter wraps. A write made in the same cycle as a wrap takes effect at the following wrap.
- R3: While disabled, a write updates the buffer and the active copy at the same clock edge. The new value governs the first period after enable.
- R4: A read returns the buffer of the addressed register: addr_i = 0 selects period, addr_i = 1 selects duty. The value returned is the last one written, even when it differs from the active value.
- R5: With pol_i = 1, the output is high while counter < duty and low for the rest of the period.
- R6: With pol_i = 0, the output is low while counter < duty and high for the rest of the period.
- R7: While enabled, the counter advances by one only on a cycle with tick_i = 1. It wraps from period−1 to 0, and both active values load from their buffers at that wrap.
- R8: Period writes follow the same buffering rule as duty writes: buffered while enabled, written through while disabled.
- R9: If duty ≥ period, the output stays at the starting level (pol_i) for the whole period. If duty = 0, it stays at the opposite level for the whole period.
- R10: If the active period is 0, the output is held at the starting level and the counter stays at 0.
- R11: While en_i = 0, the counter is held at 0 and the output equals the inverse of pol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 period, 1 duty |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Buffer of the selected register |
| en_i | input | 1 | Channel enable |
| pol_i | input | 1 | Starting level of each period |
| tick_i | input | 1 | Prescaled count enable |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that every input is synchronous to clk_i and free of unknowns once reset is released. They also assume that en_i and pol_i may change on any cycle with no settling period. The bench drives all inputs on the falling edge, so nothing changes near the sampling edge. Its random phase draws small period and duty values so that wraps, the duty ≥ period case and the zero-period case occur often. Enable and polarity switch rarely, so that whole periods run between changes.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned NUM_REGS = 2;
  localparam int unsigned REG_PER  = 0;
  localparam int unsigned REG_DUTY = 1;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int unsigned  W   = 8,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] buf_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] buf_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   buf_q <= RST;
    else if (wr_i) buf_q <= wdata_i;
  end

  // disabled: active tracks the buffer, write goes straight through
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= RST;
    else if (!en_i)  act_q <= wr_i ? wdata_i : buf_q;
    else if (load_i) act_q <= buf_q;
  end

  assign buf_o = buf_q;
  assign act_o = act_q;

  p_act_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |=> $stable(act_q));
  p_direct_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && wr_i |=> act_q == $past(wdata_i));
  p_read_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> buf_o == $past(wdata_i));
  p_load_at_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_i |=> act_q == $past(buf_q));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  assign last   = (per_i == '0) || (({1'b0, cnt_q} + 1'b1) >= {1'b0, per_i});
  assign wrap_o = en_i & tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_cnt_below_per_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_i != '0 |-> cnt_q < per_i);
  p_cnt_hold_no_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i |=> $stable(cnt_q));
  p_cnt_zero_per_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && per_i == '0 |=> cnt_q == '0);
  p_cnt_disabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o
);
  always_comb begin
    if (!en_i)              pwm_o = ~pol_i;
    else if (per_i == '0)   pwm_o = pol_i;
    else if (cnt_i < duty_i) pwm_o = pol_i;
    else                    pwm_o = ~pol_i;
  end

  p_first_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cnt_i == '0 && duty_i != '0 |-> pwm_o == pol_i);
  p_zero_duty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && per_i != '0 && duty_i == '0 |-> pwm_o != pol_i);
  p_full_duty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && duty_i >= per_i |-> pwm_o == pol_i);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] PER_RST  = '1,
  parameter logic [W-1:0] DUTY_RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic         tick_i,
  output logic         pwm_o
);
  logic [W-1:0] buf_w [NUM_REGS];
  logic [W-1:0] act_w [NUM_REGS];
  logic [W-1:0] cnt;
  logic         wrap;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic         SEL = 1'(i);
    localparam logic [W-1:0] RV  = (i == REG_DUTY) ? DUTY_RST : PER_RST;
    pwm_shadow_reg #(.W(W), .RST(RV)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .wr_i   (wr_en_i && (addr_i == SEL)),
      .wdata_i(wdata_i),
      .load_i (wrap),
      .buf_o  (buf_w[i]),
      .act_o  (act_w[i])
    );
  end

  assign rdata_o = buf_w[addr_i];

  pwm_counter #(.W(W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tick_i(tick_i),
    .per_i (act_w[REG_PER]),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  pwm_compare #(.W(W)) u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .pol_i (pol_i),
    .cnt_i (cnt),
    .per_i (act_w[REG_PER]),
    .duty_i(act_w[REG_DUTY]),
    .pwm_o (pwm_o)
  );

  p_idle_level_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> pwm_o == ~pol_i);
  p_zero_per_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && act_w[REG_PER] == '0 |-> pwm_o == pol_i);
  p_wrap_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> cnt == '0);
endmodule

// File: tb/pwm_chan_bench.sv
module pwm_chan_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, addr_i = 1'b0, en_i = 1'b0, pol_i = 1'b1, tick_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       pwm_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_pbuf, m_dbuf, m_pact, m_dact, m_cnt;

  always #2 clk = ~clk;

  pwm_chan u_pwm_chan (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .en_i(en_i), .pol_i(pol_i),
    .tick_i(tick_i), .pwm_o(pwm_o)
  );

  function automatic logic exp_pwm(logic en, logic pol, logic [7:0] cnt,
                                   logic [7:0] per, logic [7:0] duty);
    if (!en) return ~pol;
    if (per == 0) return pol;
    return (cnt < duty) ? pol : ~pol;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(logic wr, logic ad, logic [7:0] d, logic en, logic tk);
    logic [7:0] npb, ndb;
    npb = m_pbuf; ndb = m_dbuf;
    if (wr) begin
      if (ad) ndb = d; else npb = d;
    end
    if (!en) begin
      m_cnt = 0; m_pact = npb; m_dact = ndb;
    end else if (tk) begin
      if (m_pact == 0 || int'(m_cnt) + 1 >= int'(m_pact)) begin
        m_cnt = 0; m_pact = m_pbuf; m_dact = m_dbuf;
      end else m_cnt = m_cnt + 1;
    end
    m_pbuf = npb; m_dbuf = ndb;
  endtask

  task automatic step(logic wr, logic ad, logic [7:0] d, logic en, logic tk,
                      logic pl, string tag);
    @(negedge clk);
    wr_en_i = wr; addr_i = ad; wdata_i = d; en_i = en; tick_i = tk; pol_i = pl;
    @(posedge clk);
    model_update(wr, ad, d, en, tk);
    #1;
    check(tag, {7'd0, pwm_o}, {7'd0, exp_pwm(en, pl, m_cnt, m_pact, m_dact)});
    check("R4", rdata_o, ad ? m_dbuf : m_pbuf);
  endtask

  task automatic write_reg(logic ad, logic [7:0] d, logic en, logic pl, string tag);
    step(1'b1, ad, d, en, 1'b1, pl, tag);
  endtask

  task automatic count_high(int n, logic pl, string tag, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      step(1'b0, 1'b1, 8'd0, 1'b1, 1'b1, pl, tag);
      highs += int'(pwm_o);
    end
  endtask

  task automatic align(logic pl, string tag);
    while (m_cnt != 0) step(1'b0, 1'b1, 8'd0, 1'b1, 1'b1, pl, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int h;
    void'($urandom(32'h5EED_0042));
    m_pbuf = 8'hFF; m_dbuf = 8'hFF; m_pact = 8'hFF; m_dact = 8'hFF; m_cnt = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset level", {7'd0, pwm_o}, 8'd0);
    rst_ni = 1'b1;
    // R1: reset values read back
    step(1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, "R1");
    check("R1 period", rdata_o, 8'hFF);
    step(1'b0, 1'b1, 8'd0, 1'b0, 1'b0, 1'b1, "R1");
    check("R1 duty", rdata_o, 8'hFF);

    // R3/R8: disabled writes go straight through
    write_reg(1'b0, 8'd10, 1'b0, 1'b1, "R8");
    write_reg(1'b1, 8'd4, 1'b0, 1'b1, "R3");
    check("R4 duty readback", rdata_o, 8'd4);
    count_high(10, 1'b1, "R5", h);
    check("R3 first period high time", 8'(h), 8'd4);
    check("R5 high count", 8'(h), 8'd4);

    // R2: mid-period write applies from next period
    align(1'b1, "R2");
    step(1'b0, 1'b1, 8'd0, 1'b1, 1'b1, 1'b1, "R2");
    step(1'b0, 1'b1, 8'd0, 1'b1, 1'b1, 1'b1, "R2");
    write_reg(1'b1, 8'd7, 1'b1, 1'b1, "R2");
    check("R4 buffer not active", rdata_o, 8'd7);
    h = 0;
    while (m_cnt != 0) begin
      step(1'b0, 1'b1, 8'd0, 1'b1, 1'b1, 1'b1, "R2");
      if (m_cnt != 0) h += int'(pwm_o);
    end
    check("R2 old duty kept in current period", 8'(h), 8'd0);
    count_high(10, 1'b1, "R2", h);
    check("R2 new duty next period", 8'(h), 8'd7);

    // R6: polarity 0 gives low time
    count_high(10, 1'b0, "R6", h);
    check("R6 high count", 8'(h), 8'd3);

    // R7: no tick holds state
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 8'd0, 1'b1, 1'b0, 1'b1, "R7");

    // R8: enabled period write buffered
    write_reg(1'b0, 8'd5, 1'b1, 1'b1, "R8");
    align(1'b1, "R8");
    count_high(5, 1'b1, "R8", h);
    check("R8 new period high count", 8'(h), 8'd5);

    // R9: duty >= period and duty == 0
    write_reg(1'b0, 8'd6, 1'b0, 1'b1, "R9");
    write_reg(1'b1, 8'd6, 1'b0, 1'b1, "R9");
    count_high(6, 1'b1, "R9", h);
    check("R9 full duty", 8'(h), 8'd6);
    write_reg(1'b1, 8'd0, 1'b0, 1'b1, "R9");
    count_high(6, 1'b1, "R9", h);
    check("R9 zero duty", 8'(h), 8'd0);

    // R10: zero period
    write_reg(1'b0, 8'd0, 1'b0, 1'b0, "R10");
    count_high(6, 1'b0, "R10", h);
    check("R10 zero period pol0", 8'(h), 8'd0);
    count_high(6, 1'b1, "R10", h);
    check("R10 zero period pol1", 8'(h), 8'd6);

    // R11: disabled level for both polarities
    step(1'b0, 1'b1, 8'd0, 1'b0, 1'b1, 1'b1, "R11");
    check("R11 pol1", {7'd0, pwm_o}, 8'd0);
    step(1'b0, 1'b1, 8'd0, 1'b0, 1'b1, 1'b0, "R11");
    check("R11 pol0", {7'd0, pwm_o}, 8'd1);

    // random mix
    begin
      logic en_r, pol_r;
      en_r = 1'b1; pol_r = 1'b1;
      for (int k = 0; k < 4000; k++) begin
        logic wr, ad;
        logic [7:0] d;
        if ($urandom_range(0, 99) < 2) en_r = ~en_r;
        if ($urandom_range(0, 99) < 1) pol_r = ~pol_r;
        wr = ($urandom_range(0, 99) < 8);
        ad = 1'($urandom_range(0, 1));
        d  = ad ? 8'($urandom_range(0, 14)) : 8'($urandom_range(0, 12));
        step(wr, ad, d, en_r, 1'($urandom_range(0, 3) != 0), pol_r, "R7 random");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule